// File: doc/BRIEF.md
# Password-Gated Clock Control Register Bank

This block is the software-facing register file of a clock manager. It holds the control words that set up a set of PLLs, the output channels of each PLL and a group of clock multiplexers. A write is stored only when its top byte carries a fixed magic code. Before storage the block clears that byte, so a read never returns it. Every accepted write raises one-cycle update strobes towards the clock blocks that depend on the register written. The clock blocks then recompute their settings from the flat configuration vector.

One word holds no storage. Reading it returns one lock flag per PLL, built at the moment of the read from the power-down and analog-reset bits currently held for that PLL. The request port uses byte addresses and a size code. Only aligned full-word accesses take effect. Every request completes its handshake, including a rejected write, and raises no error.

With the default parameters (5 PLLs, 3 channels per PLL, 4 muxes) the word map is as follows. Words 0-4 are the PLL control words, and bit 8 of each is that PLL's analog reset. Words 5-9 are the PLL analog words, and bit 16 of each is that PLL's power-down. Word 10 is the lock status. Words 11-25 are the channel words, where channel `p*3+c` belongs to PLL `p`. Words 26-33 are the mux words, with mux `m` using word `26+2m` for control and `27+2m` for its divisor.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset each stored word holds its default. PLL control words 0,1,3 hold 0x00000021 and word 2 holds 0x00000121. PLL analog words 5-8 hold 0x00001040. Channel words of PLLs 0-3 hold 0x00000004. Even-numbered mux control words hold 0x00000011 and their divisor words hold 0x00002000. Everything else is zero, including all words of PLL 4. All strobes and rsp_valid_o are low.
- R2: A full aligned write whose bits [31:24] equal 0x5A stores the written value with bits [31:24] cleared, and a later read returns that stored value.
- R3: A write whose bits [31:24] differ from 0x5A changes no stored word and raises no strobe, yet still produces rsp_valid_o one cycle later.
- R4: An access whose size code is not 2 (full word) or whose address bits [1:0] are not zero is ignored when it is a write, and it returns 0 when it is a read.
- R5: A read of word 10 returns, in bit 8+p, a 1 exactly when PLL p has bit 8 of its control word clear and bit 16 of its analog word clear. It reflects the stored bits at the time of the read, and all other bits read 0.
- R6: Writes to word 10 or to any word at or above 34 store nothing and raise no strobe. Reads of words at or above 34 return 0.
- R7: An accepted write to PLL control word p raises pll_upd_o[p] and the chan_upd_o bits of all channels of PLL p for exactly one cycle, in the cycle after the request. No other strobe rises.
- R8: An accepted write to PLL analog word 5+p raises pll_upd_o[p] only, for one cycle.
- R9: An accepted write to channel word 11+k raises chan_upd_o[k] only, for one cycle.
- R10: An accepted write to the control or the divisor word of mux m raises mux_upd_o[m] only, for one cycle.
- R11: req_ready_o is always high. rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. For a read, rsp_rdata_o carries the value selected in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (8) | Byte address |
| req_size_i | input | 2 | Access size code, 2 = 32-bit word |
| req_wdata_i | input | 32 | Write data including password byte |
| rsp_valid_o | output | 1 | Response one cycle after request |
| rsp_rdata_o | output | 32 | Read data |
| cfg_o | output | NUM_REGS*32 (1088) | Stored words, word i at bits [32i+31:32i] |
| pll_upd_o | output | NUM_PLL (5) | Per-PLL update strobes |
| chan_upd_o | output | NUM_PLL*CHAN_PER_PLL (15) | Per-channel update strobes |
| mux_upd_o | output | NUM_MUX (4) | Per-mux update strobes |

## Verification
The bench targets several corner cases.
- A write carrying a wrong password. If the design skipped the check, or only stopped the strobes, the bench would see a changed configuration word or a stray pulse.
- Half-word and misaligned accesses. A design that decoded only the word index would corrupt a neighbouring register.
- The lock word, after the analog-reset and power-down bits are toggled. A design that stored the lock word, or read a wrong bit, would return a stale or shifted flag.
- Writes to the lock word and to unmapped words.
- The fan-out of a PLL control write to all of its channels. A design that mapped channel indices wrongly, or held a strobe for more than one cycle, would be caught by the exact strobe vector compared on every access and on the idle cycle that follows.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam logic [1:0] SIZE_WORD = 2'd2;
   localparam int unsigned ARST_BIT = 8;
   localparam int unsigned PWRDN_BIT = 16;

   typedef enum logic [2:0] {
      K_PLL_CTL,
      K_PLL_ANA,
      K_LOCK,
      K_CHAN,
      K_MUX_CTL,
      K_MUX_DIV,
      K_NONE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [7:0] unit;
   } reg_class_t;

   function automatic int unsigned ana_base(int unsigned n_pll);
      return n_pll;
   endfunction

   function automatic int unsigned lock_index(int unsigned n_pll);
      return 2 * n_pll;
   endfunction

   function automatic int unsigned chan_base(int unsigned n_pll);
      return 2 * n_pll + 1;
   endfunction

   function automatic int unsigned mux_base(int unsigned n_pll, int unsigned n_ch);
      return chan_base(n_pll) + n_pll * n_ch;
   endfunction

   function automatic int unsigned total_regs(int unsigned n_pll, int unsigned n_ch,
                                              int unsigned n_mux);
      return mux_base(n_pll, n_ch) + 2 * n_mux;
   endfunction

   // Map a word index onto the role it plays in the clock tree.
   function automatic reg_class_t classify(int unsigned idx, int unsigned n_pll,
                                           int unsigned n_ch, int unsigned n_mux);
      reg_class_t c;
      int unsigned mb;
      mb = mux_base(n_pll, n_ch);
      c.kind = K_NONE;
      c.unit = '0;
      if (idx < n_pll) begin
         c.kind = K_PLL_CTL;
         c.unit = 8'(idx);
      end else if (idx < lock_index(n_pll)) begin
         c.kind = K_PLL_ANA;
         c.unit = 8'(idx - n_pll);
      end else if (idx == lock_index(n_pll)) begin
         c.kind = K_LOCK;
      end else if (idx < mb) begin
         c.kind = K_CHAN;
         c.unit = 8'(idx - chan_base(n_pll));
      end else if (idx < mb + 2 * n_mux) begin
         c.kind = ((idx - mb) % 2 == 0) ? K_MUX_CTL : K_MUX_DIV;
         c.unit = 8'((idx - mb) / 2);
      end
      return c;
   endfunction

   // Boot values; the last PLL and everything below it has no known default.
   function automatic logic [31:0] reg_default(int unsigned idx, int unsigned n_pll,
                                               int unsigned n_ch, int unsigned n_mux);
      reg_class_t c;
      logic [31:0] v;
      c = classify(idx, n_pll, n_ch, n_mux);
      v = '0;
      case (c.kind)
         K_PLL_CTL: if (int'(c.unit) != n_pll - 1)
                       v = (c.unit == 8'd2) ? 32'h0000_0121 : 32'h0000_0021;
         K_PLL_ANA: if (int'(c.unit) != n_pll - 1) v = 32'h0000_1040;
         K_CHAN:    if (int'(c.unit) / n_ch != n_pll - 1) v = 32'h0000_0004;
         K_MUX_CTL: if (c.unit[0] == 1'b0) v = 32'h0000_0011;
         K_MUX_DIV: if (c.unit[0] == 1'b0) v = 32'h0000_2000;
         default:   v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/clkctl_req_check.sv
module clkctl_req_check
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [7:0]  PWD    = 8'h5A,
   localparam int unsigned IDX_W = ADDR_W - 2
) (
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_size_i,
   input  logic [31:0]       req_wdata_i,
   output logic              acc_ok_o,
   output logic              wr_go_o,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic [31:0]       wdata_clean_o
);

   localparam logic [31:0] KEEP_MASK = 32'h00FF_FFFF;

   logic pwd_match;

   assign acc_ok_o      = (req_size_i == SIZE_WORD) && (req_addr_i[1:0] == 2'b00);
   assign word_idx_o    = req_addr_i[ADDR_W-1:2];
   assign pwd_match     = (req_wdata_i[31:24] == PWD);
   assign wr_go_o       = req_valid_i && req_write_i && acc_ok_o && pwd_match;
   assign wdata_clean_o = req_wdata_i & KEEP_MASK;

endmodule

// File: rtl/clkctl_reg_store.sv
module clkctl_reg_store
   import clkctl_pkg::*;
#(
   parameter int unsigned NUM_PLL      = 5,
   parameter int unsigned CHAN_PER_PLL = 3,
   parameter int unsigned NUM_MUX      = 4,
   parameter int unsigned IDX_W        = 6,
   localparam int unsigned NUM_REGS    = total_regs(NUM_PLL, CHAN_PER_PLL, NUM_MUX)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_go_i,
   input  logic [IDX_W-1:0]      word_idx_i,
   input  logic [31:0]           wdata_i,
   output logic [NUM_REGS*32-1:0] cfg_o,
   output logic [NUM_REGS-1:0]   hit_o
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam reg_class_t  CL   = classify(i, NUM_PLL, CHAN_PER_PLL, NUM_MUX);
      localparam logic [31:0] DFLT = reg_default(i, NUM_PLL, CHAN_PER_PLL, NUM_MUX);
      if (CL.kind == K_LOCK) begin : g_hole
         assign cfg_o[i*32 +: 32] = '0;
         assign hit_o[i]          = 1'b0;
      end else begin : g_flop
         logic [31:0] q;
         assign hit_o[i] = wr_go_i && (word_idx_i == IDX_W'(i));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               q <= DFLT;
            end else if (hit_o[i]) begin
               q <= wdata_i;
            end
         end
         assign cfg_o[i*32 +: 32] = q;
      end
   end

endmodule

// File: rtl/clkctl_strobe_gen.sv
module clkctl_strobe_gen
   import clkctl_pkg::*;
#(
   parameter int unsigned NUM_PLL      = 5,
   parameter int unsigned CHAN_PER_PLL = 3,
   parameter int unsigned NUM_MUX      = 4,
   parameter bit          STROBE_REG   = 1'b1,
   localparam int unsigned NUM_REGS    = total_regs(NUM_PLL, CHAN_PER_PLL, NUM_MUX),
   localparam int unsigned NUM_CHAN    = NUM_PLL * CHAN_PER_PLL
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_REGS-1:0] hit_i,
   output logic [NUM_PLL-1:0]  pll_upd_o,
   output logic [NUM_CHAN-1:0] chan_upd_o,
   output logic [NUM_MUX-1:0]  mux_upd_o
);

   localparam int unsigned ANA_B  = ana_base(NUM_PLL);
   localparam int unsigned LOCK_I = lock_index(NUM_PLL);
   localparam int unsigned CHAN_B = chan_base(NUM_PLL);
   localparam int unsigned MUX_B  = mux_base(NUM_PLL, CHAN_PER_PLL);

   logic [NUM_PLL-1:0]  pll_d;
   logic [NUM_CHAN-1:0] chan_d;
   logic [NUM_MUX-1:0]  mux_d;
   logic                unused_lock_hit;

   assign unused_lock_hit = hit_i[LOCK_I];

   always_comb begin
      pll_d  = '0;
      chan_d = '0;
      mux_d  = '0;
      for (int p = 0; p < NUM_PLL; p++) begin
         // shared control word fans out to the PLL and every channel under it
         if (hit_i[p]) begin
            pll_d[p] = 1'b1;
            chan_d[p*CHAN_PER_PLL +: CHAN_PER_PLL] = '1;
         end
         if (hit_i[ANA_B + p]) begin
            pll_d[p] = 1'b1;
         end
      end
      for (int k = 0; k < NUM_CHAN; k++) begin
         if (hit_i[CHAN_B + k]) begin
            chan_d[k] = 1'b1;
         end
      end
      for (int m = 0; m < NUM_MUX; m++) begin
         if (hit_i[MUX_B + 2*m] || hit_i[MUX_B + 2*m + 1]) begin
            mux_d[m] = 1'b1;
         end
      end
   end

   if (STROBE_REG) begin : g_reg_strobe
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pll_upd_o  <= '0;
            chan_upd_o <= '0;
            mux_upd_o  <= '0;
         end else begin
            pll_upd_o  <= pll_d;
            chan_upd_o <= chan_d;
            mux_upd_o  <= mux_d;
         end
      end
   end else begin : g_comb_strobe
      assign pll_upd_o  = pll_d;
      assign chan_upd_o = chan_d;
      assign mux_upd_o  = mux_d;
   end

endmodule

// File: rtl/clkctl_lock_view.sv
module clkctl_lock_view #(
   parameter int unsigned NUM_PLL  = 5,
   parameter int unsigned LOCK_LSB = 8
) (
   input  logic [NUM_PLL-1:0] arst_i,
   input  logic [NUM_PLL-1:0] pwrdn_i,
   output logic [31:0]        lock_word_o
);

   always_comb begin
      lock_word_o = '0;
      for (int p = 0; p < NUM_PLL; p++) begin
         lock_word_o[LOCK_LSB + p] = ~arst_i[p] & ~pwrdn_i[p];
      end
   end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int unsigned NUM_PLL      = 5,
   parameter int unsigned CHAN_PER_PLL = 3,
   parameter int unsigned NUM_MUX      = 4,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned LOCK_LSB     = 8,
   parameter logic [7:0]  PWD          = 8'h5A,
   parameter bit          STROBE_REG   = 1'b1,
   localparam int unsigned NUM_REGS    = total_regs(NUM_PLL, CHAN_PER_PLL, NUM_MUX),
   localparam int unsigned NUM_CHAN    = NUM_PLL * CHAN_PER_PLL
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   req_valid_i,
   output logic                   req_ready_o,
   input  logic                   req_write_i,
   input  logic [ADDR_W-1:0]      req_addr_i,
   input  logic [1:0]             req_size_i,
   input  logic [31:0]            req_wdata_i,
   output logic                   rsp_valid_o,
   output logic [31:0]            rsp_rdata_o,
   output logic [NUM_REGS*32-1:0] cfg_o,
   output logic [NUM_PLL-1:0]     pll_upd_o,
   output logic [NUM_CHAN-1:0]    chan_upd_o,
   output logic [NUM_MUX-1:0]     mux_upd_o
);

   localparam int unsigned IDX_W  = ADDR_W - 2;
   localparam int unsigned LOCK_I = lock_index(NUM_PLL);
   localparam int unsigned ANA_B  = ana_base(NUM_PLL);

   if (NUM_PLL < 1 || NUM_PLL + LOCK_LSB > 24) begin : g_bad_lock
      $error("lock flags must fit below the password byte");
   end
   if (NUM_REGS > (1 << IDX_W)) begin : g_bad_addr
      $error("address width too small for the register map");
   end
   if (NUM_CHAN > 255 || NUM_MUX > 255 || CHAN_PER_PLL < 1) begin : g_bad_count
      $error("unit counts out of range");
   end

   logic              acc_ok;
   logic              wr_go;
   logic [IDX_W-1:0]  word_idx;
   logic [31:0]       wdata_clean;
   logic [NUM_REGS-1:0] hit;
   logic [NUM_PLL-1:0]  arst_bits;
   logic [NUM_PLL-1:0]  pwrdn_bits;
   logic [31:0]       lock_word;
   logic [31:0]       rd_word;

   assign req_ready_o = 1'b1;

   clkctl_req_check #(
      .ADDR_W (ADDR_W),
      .PWD    (PWD)
   ) u_req (
      .req_valid_i   (req_valid_i),
      .req_write_i   (req_write_i),
      .req_addr_i    (req_addr_i),
      .req_size_i    (req_size_i),
      .req_wdata_i   (req_wdata_i),
      .acc_ok_o      (acc_ok),
      .wr_go_o       (wr_go),
      .word_idx_o    (word_idx),
      .wdata_clean_o (wdata_clean)
   );

   clkctl_reg_store #(
      .NUM_PLL      (NUM_PLL),
      .CHAN_PER_PLL (CHAN_PER_PLL),
      .NUM_MUX      (NUM_MUX),
      .IDX_W        (IDX_W)
   ) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_go_i    (wr_go),
      .word_idx_i (word_idx),
      .wdata_i    (wdata_clean),
      .cfg_o      (cfg_o),
      .hit_o      (hit)
   );

   clkctl_strobe_gen #(
      .NUM_PLL      (NUM_PLL),
      .CHAN_PER_PLL (CHAN_PER_PLL),
      .NUM_MUX      (NUM_MUX),
      .STROBE_REG   (STROBE_REG)
   ) u_strobe (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit),
      .pll_upd_o  (pll_upd_o),
      .chan_upd_o (chan_upd_o),
      .mux_upd_o  (mux_upd_o)
   );

   for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock_tap
      assign arst_bits[p]  = cfg_o[p*32 + ARST_BIT];
      assign pwrdn_bits[p] = cfg_o[(ANA_B + p)*32 + PWRDN_BIT];
   end

   clkctl_lock_view #(
      .NUM_PLL  (NUM_PLL),
      .LOCK_LSB (LOCK_LSB)
   ) u_lock (
      .arst_i      (arst_bits),
      .pwrdn_i     (pwrdn_bits),
      .lock_word_o (lock_word)
   );

   always_comb begin
      rd_word = '0;
      if (acc_ok) begin
         if (word_idx == IDX_W'(LOCK_I)) begin
            rd_word = lock_word;
         end else if (int'(word_idx) < int'(NUM_REGS)) begin
            rd_word = cfg_o[int'(word_idx)*32 +: 32];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         if (req_valid_i && !req_write_i) begin
            rsp_rdata_o <= rd_word;
         end
      end
   end

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk
   import clkctl_pkg::*;
#(
   parameter int unsigned NUM_PLL      = 5,
   parameter int unsigned CHAN_PER_PLL = 3,
   parameter int unsigned NUM_MUX      = 4,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned LOCK_LSB     = 8,
   parameter logic [7:0]  PWD          = 8'h5A,
   parameter bit          STROBE_REG   = 1'b1,
   localparam int unsigned NUM_REGS    = total_regs(NUM_PLL, CHAN_PER_PLL, NUM_MUX),
   localparam int unsigned NUM_CHAN    = NUM_PLL * CHAN_PER_PLL
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   req_valid_i,
   input logic                   req_ready_o,
   input logic                   req_write_i,
   input logic [ADDR_W-1:0]      req_addr_i,
   input logic [1:0]             req_size_i,
   input logic [31:0]            req_wdata_i,
   input logic                   rsp_valid_o,
   input logic [31:0]            rsp_rdata_o,
   input logic [NUM_REGS*32-1:0] cfg_o,
   input logic [NUM_PLL-1:0]     pll_upd_o,
   input logic [NUM_CHAN-1:0]    chan_upd_o,
   input logic [NUM_MUX-1:0]     mux_upd_o
);

   localparam int unsigned LOCK_I = lock_index(NUM_PLL);
   localparam int unsigned ANA_B  = ana_base(NUM_PLL);

   logic bad_pwd_wr;
   logic bad_shape_wr;
   logic lock_rd;
   logic any_strobe;
   logic [NUM_PLL-1:0] lock_calc;

   assign bad_pwd_wr   = req_valid_i && req_write_i && (req_wdata_i[31:24] != PWD);
   assign bad_shape_wr = req_valid_i && req_write_i &&
                         ((req_size_i != SIZE_WORD) || (req_addr_i[1:0] != 2'b00));
   assign lock_rd      = req_valid_i && !req_write_i && (req_size_i == SIZE_WORD) &&
                         (req_addr_i == ADDR_W'(LOCK_I * 4));
   assign any_strobe   = (|pll_upd_o) || (|chan_upd_o) || (|mux_upd_o);

   always_comb begin
      for (int p = 0; p < NUM_PLL; p++) begin
         lock_calc[p] = !cfg_o[p*32 + ARST_BIT] && !cfg_o[(ANA_B + p)*32 + PWRDN_BIT];
      end
   end

   // R11: every request gets exactly one response beat
   p_rsp_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);
   p_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);

   // R3 / R4: rejected writes leave storage untouched
   p_bad_pwd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_pwd_wr |=> $stable(cfg_o));
   p_bad_shape_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_shape_wr |=> $stable(cfg_o));

   // R5: lock word tracks the stored bits live
   p_lock_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_rd |=> (rsp_rdata_o[LOCK_LSB +: NUM_PLL] == $past(lock_calc)));

   // R10: a single write touches at most one mux
   p_mux_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(mux_upd_o));

   // R2: the password byte never lands in storage
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_pwd
      p_pwd_stripped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cfg_o[i*32 + 24 +: 8] == 8'h00);
   end

   if (STROBE_REG) begin : g_reg_chk
      // R3: no strobe after a password miss
      p_bad_pwd_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         bad_pwd_wr |=> !any_strobe);
      // R7: strobes only follow a write request
      p_strobe_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         any_strobe |-> $past(req_valid_i && req_write_i));
   end else begin : g_comb_chk
      p_bad_pwd_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         bad_pwd_wr |-> !any_strobe);
   end

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
   .NUM_PLL      (NUM_PLL),
   .CHAN_PER_PLL (CHAN_PER_PLL),
   .NUM_MUX      (NUM_MUX),
   .ADDR_W       (ADDR_W),
   .LOCK_LSB     (LOCK_LSB),
   .PWD          (PWD),
   .STROBE_REG   (STROBE_REG)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .req_write_i (req_write_i),
   .req_addr_i  (req_addr_i),
   .req_size_i  (req_size_i),
   .req_wdata_i (req_wdata_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_rdata_o (rsp_rdata_o),
   .cfg_o       (cfg_o),
   .pll_upd_o   (pll_upd_o),
   .chan_upd_o  (chan_upd_o),
   .mux_upd_o   (mux_upd_o)
);

// File: tb/tb_clkctl_regbank.sv
module tb_clkctl_regbank;

   localparam int NP = 5;
   localparam int NC = 3;
   localparam int NM = 4;
   localparam int LOCKW = 10;
   localparam int CHB = 11;
   localparam int MXB = 26;
   localparam int NR = 34;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [7:0]    req_addr = '0;
   logic [1:0]    req_size = 2'd2;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic [NR*32-1:0] cfg;
   logic [NP-1:0]    pll_upd;
   logic [NP*NC-1:0] chan_upd;
   logic [NM-1:0]    mux_upd;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] model [NR];

   always #5 clk = ~clk;

   clkctl_regbank dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready),
      .req_write_i (req_write),
      .req_addr_i  (req_addr),
      .req_size_i  (req_size),
      .req_wdata_i (req_wdata),
      .rsp_valid_o (rsp_valid),
      .rsp_rdata_o (rsp_rdata),
      .cfg_o       (cfg),
      .pll_upd_o   (pll_upd),
      .chan_upd_o  (chan_upd),
      .mux_upd_o   (mux_upd)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R1 boot values written out per range
   function automatic logic [31:0] boot_val(int w);
      if (w < NP) return (w == NP-1) ? 32'h0 : ((w == 2) ? 32'h121 : 32'h21);
      if (w < 2*NP) return (w == 2*NP-1) ? 32'h0 : 32'h1040;
      if (w == LOCKW) return 32'h0;
      if (w < MXB) return ((w - CHB) / NC == NP-1) ? 32'h0 : 32'h4;
      if (w < NR) begin
         if (((w - MXB) / 2) % 2 == 0) return ((w - MXB) % 2 == 0) ? 32'h11 : 32'h2000;
         return 32'h0;
      end
      return 32'h0;
   endfunction

   function automatic logic [31:0] lock_exp();
      logic [31:0] v = '0;
      for (int p = 0; p < NP; p++) v[8+p] = !model[p][8] && !model[NP+p][16];
      return v;
   endfunction

   function automatic logic [31:0] read_exp(int w, logic [1:0] off, logic [1:0] sz);
      if (sz != 2'd2 || off != 2'd0) return 32'h0;
      if (w == LOCKW) return lock_exp();
      if (w < NR) return model[w];
      return 32'h0;
   endfunction

   task automatic idle_check();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 idle rsp", 64'(rsp_valid), 64'h0);
      chk({pll_upd, chan_upd, mux_upd} == '0, "R7 strobe one cycle",
          64'({pll_upd, chan_upd, mux_upd}), 64'h0);
   endtask

   task automatic access(input logic wr, input int w, input logic [1:0] off,
                         input logic [1:0] sz, input logic [31:0] data, input string req);
      logic [31:0] erd;
      logic [NP-1:0] ep;
      logic [NP*NC-1:0] ec;
      logic [NM-1:0] em;
      bit acc;
      erd = read_exp(w, off, sz);
      ep = '0; ec = '0; em = '0;
      acc = wr && sz == 2'd2 && off == 2'd0 && data[31:24] == 8'h5A && w < NR && w != LOCKW;
      if (acc) begin
         model[w] = data & 32'h00FF_FFFF;
         if (w < NP) begin ep[w] = 1'b1; ec[w*NC +: NC] = '1; end
         else if (w < 2*NP) ep[w-NP] = 1'b1;
         else if (w >= CHB && w < MXB) ec[w-CHB] = 1'b1;
         else if (w >= MXB) em[(w-MXB)/2] = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 8'(w*4 + int'(off));
      req_size = sz; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1 && req_ready == 1'b1, "R11 response", 64'(rsp_valid), 64'h1);
      if (!wr) chk(rsp_rdata == erd, req, 64'(rsp_rdata), 64'(erd));
      chk({pll_upd, chan_upd, mux_upd} == {ep, ec, em}, req,
          64'({pll_upd, chan_upd, mux_upd}), 64'({ep, ec, em}));
      for (int i = 0; i < NR; i++) begin
         if (cfg[i*32 +: 32] !== model[i]) begin
            chk(1'b0, req, 64'(cfg[i*32 +: 32]), 64'(model[i]));
            break;
         end
      end
      checks++;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NR; i++) model[i] = boot_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 rsp low", 64'(rsp_valid), 64'h0);
      chk({pll_upd, chan_upd, mux_upd} == '0, "R1 strobes low",
          64'({pll_upd, chan_upd, mux_upd}), 64'h0);
      for (int w = 0; w < NR + 3; w++) access(1'b0, w, 2'd0, 2'd2, 32'h0, "R1 reset read");
      access(1'b0, LOCKW, 2'd0, 2'd2, 32'h0, "R5 reset lock 0x1B00");
      chk(lock_exp() == 32'h0000_1B00, "R5 lock default", 64'(lock_exp()), 64'h1B00);
      // R2 password stripped
      access(1'b1, CHB+4, 2'd0, 2'd2, 32'h5AAB_CDEF, "R9 channel write");
      access(1'b0, CHB+4, 2'd0, 2'd2, 32'h0, "R2 readback stripped");
      // R3 bad password
      access(1'b1, CHB+4, 2'd0, 2'd2, 32'h5B00_0001, "R3 bad password");
      access(1'b1, MXB, 2'd0, 2'd2, 32'hA500_0000, "R3 bad password mux");
      // R4 shape
      access(1'b1, MXB+3, 2'd0, 2'd1, 32'h5A00_1234, "R4 half write");
      access(1'b1, MXB+3, 2'd2, 2'd2, 32'h5A00_1234, "R4 misaligned write");
      access(1'b0, MXB, 2'd1, 2'd2, 32'h0, "R4 misaligned read");
      access(1'b0, MXB, 2'd0, 2'd0, 32'h0, "R4 byte read");
      // R5 / R7 lock toggles through control and analog words
      access(1'b1, 2, 2'd0, 2'd2, 32'h5A00_0021, "R7 pll ctl fanout");
      access(1'b0, LOCKW, 2'd0, 2'd2, 32'h0, "R5 lock after arst clear");
      idle_check();
      access(1'b1, NP+0, 2'd0, 2'd2, 32'h5A01_0000, "R8 pll ana only");
      access(1'b0, LOCKW, 2'd0, 2'd2, 32'h0, "R5 lock after power down");
      access(1'b1, NP-1, 2'd0, 2'd2, 32'h5A00_0100, "R7 last pll fanout");
      access(1'b0, LOCKW, 2'd0, 2'd2, 32'h0, "R5 lock last pll");
      // R6 lock and unmapped writes
      access(1'b1, LOCKW, 2'd0, 2'd2, 32'h5AFF_FFFF, "R6 lock write ignored");
      access(1'b0, LOCKW, 2'd0, 2'd2, 32'h0, "R6 lock unchanged");
      access(1'b1, 40, 2'd0, 2'd2, 32'h5A12_3456, "R6 unmapped write");
      access(1'b0, 40, 2'd0, 2'd2, 32'h0, "R6 unmapped read");
      // R10 mux words
      access(1'b1, MXB+7, 2'd0, 2'd2, 32'h5A00_3000, "R10 mux div");
      access(1'b1, MXB+2, 2'd0, 2'd2, 32'h5A00_0015, "R10 mux ctl");
      idle_check();
      // random mix
      for (int n = 0; n < 600; n++) begin
         int w;
         logic [1:0] off, sz;
         logic [31:0] d;
         logic wr;
         string req;
         w = int'($urandom_range(0, 39));
         off = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
         sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 1)) : 2'd2;
         wr = 1'($urandom_range(0, 1));
         d = $urandom;
         if ($urandom_range(0, 9) < 8) d[31:24] = 8'h5A;
         if (off != 0 || sz != 2) req = "R4 random shape";
         else if (wr && d[31:24] != 8'h5A) req = "R3 random password";
         else if (w == LOCKW) req = "R5 random lock";
         else if (w >= NR) req = "R6 random unmapped";
         else if (w < NP) req = "R7 random pll ctl";
         else if (w < 2*NP) req = "R8 random pll ana";
         else if (w < MXB) req = "R9 random channel";
         else req = "R10 random mux";
         if (!wr && req == "R7 random pll ctl") req = "R2 random read";
         access(wr, w, off, sz, d, req);
         if (n % 50 == 0) idle_check();
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule